// File: doc/BRIEF.md
# Internal Bus Ownership Arbiter

This block decides, one transfer cycle at a time, which of four masters drives the internal bus. The four masters are two DMA channels, the CPU and an external device that asks for the bus with a hold request. The owner is held in a register. A new owner is chosen only at a cycle boundary, which the bus sequencer marks by pulsing `cycle_done_i`. The one exception is the end of an external hold: the bus is taken back from the external holder on the first edge at which its hold request is seen low.

At a boundary the choice is made in this order:

1. An external hold request wins.
2. If the CPU owns the bus and is inside a locked sequence or between the two halves of an odd-address word access, the CPU keeps the bus.
3. Otherwise a DMA request wins over the CPU.
4. With nothing else pending, the bus falls back to the CPU.

Between the two channels, priority is fixed when their priority bits differ. When the bits are equal, the channels take turns.

A non-maskable interrupt sets a halt flag that blocks every DMA grant until software clears it with `nmi_clr_i`. A transfer already in progress is allowed to finish. Ordinary interrupts have no input here and never pause DMA.

Top module: `bus_arbiter`

## Requirements
- R1: During and after reset, before any boundary, `gnt_cpu_o` is 1, `gnt_dma_o` is 0, `gnt_ext_o` is 0 and `hold_ack_o` is 0.
- R2: Exactly one of `gnt_dma_o[0]`, `gnt_dma_o[1]`, `gnt_cpu_o` and `gnt_ext_o` is high in every cycle.
- R3: While the external holder does not own the bus, the grants change only on a clock edge where `cycle_done_i` is 1.
- R4: When both channels request at a boundary and `dma_prio_i[0]` differs from `dma_prio_i[1]`, the channel whose priority bit is 1 is granted on the next cycle.
- R5: When both channels request at a boundary and the two priority bits are equal, the grant goes to the favoured channel. Channel 0 is favoured after reset. Every DMA grant made in equal-priority mode makes the other channel the favoured one.
- R6: A single requesting channel wins the bus from the CPU at a boundary. Bit i of `dma_req_i` and of `gnt_dma_o` belongs to channel i.
- R7: If the CPU owns the bus and either `cpu_lock_i` or `cpu_odd_split_i` is 1 at a boundary, the CPU keeps the bus, even when DMA requests are pending.
- R8: A `hold_req_i` seen at a boundary gives the bus to the external holder on the next cycle. This overrides DMA requests and CPU lock. `hold_ack_o` is high exactly while the external holder owns the bus.
- R9: While the external holder owns the bus, `hold_ack_o` stays high as long as `hold_req_i` is 1. It falls on the cycle after `hold_req_i` is first seen low, without waiting for `cycle_done_i`.
- R10: An edge with `nmi_i` at 1 sets a halt flag, and no DMA grant is made at that edge or at any later one until `nmi_clr_i` clears the flag. A DMA transfer in progress keeps its grant until its boundary. When `nmi_i` and `nmi_clr_i` are high together, the flag is set.
- R11: When nothing is requesting at a boundary, the CPU gets the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_req_i | input | 2 | DMA request, bit per channel |
| dma_prio_i | input | 2 | Channel priority bits |
| cpu_lock_i | input | 1 | CPU is in a locked access sequence |
| cpu_odd_split_i | input | 1 | CPU is between halves of an odd-address word access |
| hold_req_i | input | 1 | External bus hold request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| nmi_clr_i | input | 1 | Clears the NMI halt flag |
| cycle_done_i | input | 1 | Current transfer cycle ends this clock |
| gnt_dma_o | output | 2 | DMA grant, bit per channel |
| gnt_cpu_o | output | 1 | CPU owns the bus |
| gnt_ext_o | output | 1 | External holder owns the bus |
| hold_ack_o | output | 1 | Hold acknowledge |

## Verification
The bench goes after the following corner cases:

- **Alternation pointer.** A pointer that fails to toggle, or that starts on the wrong channel, starves one channel when both request in equal-priority mode.
- **Fixed priority.** Reading the priority bits the wrong way round grants the wrong channel.
- **Lock and split guards.** If these are missing, a DMA channel cuts into a locked or split CPU access.
- **NMI.** Halting at once, instead of at the boundary, drops a grant in mid-transfer. Clearing the flag too early lets DMA back in before software has run.
- **End of hold.** The release of a hold is checked both with and without `cycle_done_i`. A design that waits for a boundary keeps `hold_ack_o` high too long.

Random traffic with a fixed seed mixes all of these inputs against a bench model.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned OWN_W  = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_CPU = 2'd0,
    OWN_CH0 = 2'd1,
    OWN_CH1 = 2'd2,
    OWN_EXT = 2'd3
  } owner_e;
endpackage

// File: rtl/chan_pick.sv
module chan_pick
  import arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] prio_i,
  input  logic              take_i,
  output logic              any_o,
  output logic              sel_o
);
  logic ptr_q;
  logic equal_prio;

  assign equal_prio = (prio_i[0] == prio_i[1]);
  assign any_o      = |req_i;

  always_comb begin
    if (req_i[0] && req_i[1]) sel_o = equal_prio ? ptr_q : prio_i[1];
    else                      sel_o = req_i[1];
  end

  // pointer names the channel favoured next; reset favours channel 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_q <= 1'b0;
    else if (take_i && equal_prio) ptr_q <= ~sel_o;
  end
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic nmi_clr_i,
  output logic dma_ok_o
);
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_q <= 1'b0;
    else if (nmi_i)     halt_q <= 1'b1;
    else if (nmi_clr_i) halt_q <= 1'b0;
  end

  assign dma_ok_o = !halt_q && !nmi_i;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dma_req_i,
  input  logic [NUM_CH-1:0] dma_prio_i,
  input  logic              cpu_lock_i,
  input  logic              cpu_odd_split_i,
  input  logic              hold_req_i,
  input  logic              nmi_i,
  input  logic              nmi_clr_i,
  input  logic              cycle_done_i,
  output logic [NUM_CH-1:0] gnt_dma_o,
  output logic              gnt_cpu_o,
  output logic              gnt_ext_o,
  output logic              hold_ack_o
);
  owner_e own_q, own_d;
  logic   boundary, any_req, sel_ch, dma_ok, take;

  chan_pick u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (dma_req_i),
    .prio_i (dma_prio_i),
    .take_i (take),
    .any_o  (any_req),
    .sel_o  (sel_ch)
  );

  nmi_gate u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nmi_i     (nmi_i),
    .nmi_clr_i (nmi_clr_i),
    .dma_ok_o  (dma_ok)
  );

  // external holder releases on request drop, others at cycle end
  assign boundary = (own_q == OWN_EXT) ? !hold_req_i : cycle_done_i;

  always_comb begin
    own_d = own_q;
    take  = 1'b0;
    if (boundary) begin
      if (hold_req_i && own_q != OWN_EXT) begin
        own_d = OWN_EXT;
      end else if (own_q == OWN_CPU && (cpu_lock_i || cpu_odd_split_i)) begin
        own_d = OWN_CPU;
      end else if (any_req && dma_ok) begin
        own_d = sel_ch ? OWN_CH1 : OWN_CH0;
        take  = 1'b1;
      end else begin
        own_d = OWN_CPU;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= OWN_CPU;
    else         own_q <= own_d;
  end

  assign gnt_cpu_o    = (own_q == OWN_CPU);
  assign gnt_dma_o[0] = (own_q == OWN_CH0);
  assign gnt_dma_o[1] = (own_q == OWN_CH1);
  assign gnt_ext_o    = (own_q == OWN_EXT);
  assign hold_ack_o   = gnt_ext_o;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk
  import arb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] dma_req_i,
  input logic [NUM_CH-1:0] dma_prio_i,
  input logic              cpu_lock_i,
  input logic              cpu_odd_split_i,
  input logic              hold_req_i,
  input logic              nmi_i,
  input logic              nmi_clr_i,
  input logic              cycle_done_i,
  input logic [NUM_CH-1:0] gnt_dma_o,
  input logic              gnt_cpu_o,
  input logic              gnt_ext_o,
  input logic              hold_ack_o
);
  // R2
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gnt_dma_o, gnt_cpu_o, gnt_ext_o}) == 1);

  // R3
  boundary_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_done_i && !gnt_ext_o) |=> $stable({gnt_dma_o, gnt_cpu_o, gnt_ext_o}));

  // R7
  cpu_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_cpu_o && cycle_done_i && !hold_req_i && (cpu_lock_i || cpu_odd_split_i))
    |=> gnt_cpu_o);

  // R8
  hold_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_done_i && hold_req_i && !gnt_ext_o) |=> (gnt_ext_o && hold_ack_o));

  // R9
  hold_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && !hold_req_i) |=> !hold_ack_o);

  // R10
  nmi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && gnt_dma_o == '0) |=> gnt_dma_o == '0);
endmodule

bind bus_arbiter bus_arbiter_chk u_chk (.*);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] dma_req_i = '0, dma_prio_i = '0;
  logic       cpu_lock_i = 0, cpu_odd_split_i = 0, hold_req_i = 0;
  logic       nmi_i = 0, nmi_clr_i = 0, cycle_done_i = 0;
  logic [1:0] gnt_dma_o;
  logic       gnt_cpu_o, gnt_ext_o, hold_ack_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model: 0 cpu, 1 ch0, 2 ch1, 3 ext
  logic [1:0] m_own = 2'd0;
  logic       m_ptr = 1'b0;
  logic       m_halt = 1'b0;

  always #5 clk_i = ~clk_i;

  bus_arbiter u_dut (.*);

  function automatic logic [4:0] exp_vec(logic [1:0] own);
    // {ch1, ch0, cpu, ext, ack}
    return {own == 2'd2, own == 2'd1, own == 2'd0, own == 2'd3, own == 2'd3};
  endfunction

  task automatic check(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {gnt_dma_o[1], gnt_dma_o[0], gnt_cpu_o, gnt_ext_o, hold_ack_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grants {ch1,ch0,cpu,ext,ack} actual %b expected %b", tag, act, exp);
    end
    checks++;
    if ($countones(act[4:1]) != 1) begin
      errors++;
      $display("FAIL R2: grants actual %b expected one-hot", act[4:1]);
    end
  endtask

  task automatic step(logic [1:0] req, logic [1:0] pr, logic lk, logic sp,
                      logic hr, logic nm, logic nc, logic cd);
    logic       bnd, ch;
    logic [1:0] nxt;
    string      tag;
    dma_req_i = req; dma_prio_i = pr; cpu_lock_i = lk; cpu_odd_split_i = sp;
    hold_req_i = hr; nmi_i = nm; nmi_clr_i = nc; cycle_done_i = cd;
    bnd = (m_own == 2'd3) ? !hr : cd;
    nxt = m_own;
    tag = "R3";
    if (bnd) begin
      if (hr && m_own != 2'd3) begin
        nxt = 2'd3; tag = "R8";
      end else if (m_own == 2'd0 && (lk || sp)) begin
        nxt = 2'd0; tag = "R7";
      end else if (req != 2'b00 && !m_halt && !nm) begin
        if (req == 2'b11) begin
          if (pr[0] != pr[1]) begin ch = pr[1]; tag = "R4"; end
          else begin ch = m_ptr; tag = "R5"; end
        end else begin
          ch = req[1]; tag = "R6";
        end
        if (pr[0] == pr[1]) m_ptr = ~ch;
        nxt = ch ? 2'd2 : 2'd1;
      end else begin
        nxt = 2'd0;
        tag = (req != 2'b00) ? "R10" : "R11";
      end
      if (m_own == 2'd3) tag = {tag, "/R9"};
    end else if (m_own == 2'd3) begin
      tag = "R9";
    end else if (nm) begin
      tag = "R10";
    end
    if (nm) m_halt = 1'b1;
    else if (nc) m_halt = 1'b0;
    m_own = nxt;
    @(negedge clk_i);
    check(tag, exp_vec(m_own));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk_i);
    check("R1", exp_vec(2'd0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", exp_vec(2'd0));

    // R4 fixed priority, both directions
    step(2'b11, 2'b10, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b01, 0, 0, 0, 0, 0, 1);
    // R3 no change without boundary
    step(2'b10, 2'b00, 0, 0, 0, 0, 0, 0);
    // R5 alternation, pointer starts at channel 0
    step(2'b11, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b11, 0, 0, 0, 0, 0, 1);
    // R11 idle returns to CPU, R7 lock and split guards
    step(2'b00, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b00, 1, 0, 0, 0, 0, 1);
    step(2'b01, 2'b00, 0, 1, 0, 0, 0, 1);
    // R6 single request beats CPU
    step(2'b01, 2'b00, 0, 0, 0, 0, 0, 1);
    // R8 hold waits for boundary, then wins over DMA
    step(2'b11, 2'b00, 0, 0, 1, 0, 0, 0);
    step(2'b11, 2'b00, 1, 0, 1, 0, 0, 1);
    step(2'b11, 2'b00, 0, 0, 1, 0, 0, 1);
    // R9 release without cycle_done
    step(2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
    // R10 nmi during a transfer: finish, then block until cleared
    step(2'b10, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b10, 2'b00, 0, 0, 0, 1, 1, 0);
    step(2'b10, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b00, 0, 0, 0, 0, 0, 1);
    step(2'b11, 2'b00, 0, 0, 0, 0, 1, 1);
    step(2'b11, 2'b00, 0, 0, 0, 0, 0, 1);

    for (int i = 0; i < 5000; i++) begin
      step($urandom_range(3, 0), $urandom_range(3, 0),
           ($urandom_range(7, 0) == 0), ($urandom_range(7, 0) == 0),
           ($urandom_range(9, 0) < 2), ($urandom_range(63, 0) == 0),
           ($urandom_range(7, 0) == 0), ($urandom_range(2, 0) != 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule